// File: doc/BRIEF.md
# Edge-Pulse Isolated On/Off Link

This block moves one on/off command from a ground-side domain to a floating domain without sending a steady level. The sending half watches the command. It emits a fixed-length pulse on a turn-on wire when the command goes high, and a pulse on a separate turn-off wire when the command goes low. A pulse that becomes due while another is still in flight is held back and sent as soon as the wire frees up.

The receiving half checks each wire before it trusts it. A wire must be active on its own for a run of consecutive cycles before its pulse is taken. Any cycle in which both wires are active is treated as common-mode disturbance and restarts both runs. An accepted turn-on pulse sets a held output, and an accepted turn-off pulse clears it. A supply-fault flag in the receiving domain forces the output off. After the fault goes away, the output stays off until a new turn-on pulse qualifies.

The transmitter outputs and the receiver inputs are separate ports. The integrator wires them through the isolation path, and a test can inject disturbance between them. Both halves share one clock and one synchronous active-low reset.

Top module: `edge_pulse_link`

## Requirements
- R1: A low-to-high change of `cmdIn` (high when sampled, low at the previous sample) drives `chanSetOut` high from the next cycle for exactly PULSE_LEN cycles. A high-to-low change drives `chanRstOut` in the same way. A steady command level, whether high or low, sends no pulse.
- R2: The transmitter never drives `chanSetOut` and `chanRstOut` high in the same cycle. A queued pulse may start in the cycle right after the previous pulse ends.
- R3: A command change sampled while a pulse is in flight is queued and sent immediately after that pulse. Only the most recent queued change is kept. A change sampled in a pulse's final cycle is sent next in place of any queued one.
- R4: A receiver wire that is high while the other is low for QUAL_LEN consecutive cycles is accepted. The turn-on wire (`rxSetIn`) drives `driveOut` to 1 and the turn-off wire (`rxRstIn`) drives it to 0. `driveOut` changes in the cycle after the QUAL_LEN-th qualifying sample. Each run is accepted at most once.
- R5: A solo run shorter than QUAL_LEN cycles has no effect, and `driveOut` holds its value.
- R6: A cycle with `rxSetIn` and `rxRstIn` both high restarts both qualification runs and leaves `driveOut` unchanged.
- R7: While `faultIn` is sampled high, `driveOut` is 0 from the next cycle, and turn-on pulses that qualify during the fault have no effect.
- R8: After `faultIn` returns low, `driveOut` stays 0 until a turn-on run completes its QUAL_LEN-th cycle with the fault low.
- R9: `rstN` low at a clock edge clears the command history, any pulse in flight, the queued change, both qualification runs and `driveOut`. All three outputs are 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both halves |
| rstN | input | 1 | Synchronous reset, active low |
| cmdIn | input | 1 | On/off command on the sending side |
| faultIn | input | 1 | Receiving-side supply fault, active high |
| rxSetIn | input | 1 | Turn-on wire as it arrives at the receiver |
| rxRstIn | input | 1 | Turn-off wire as it arrives at the receiver |
| chanSetOut | output | 1 | Turn-on pulse sent by the transmitter |
| chanRstOut | output | 1 | Turn-off pulse sent by the transmitter |
| driveOut | output | 1 | Held output state in the receiving domain |

## Verification
A command change sampled at one edge shows on a transmitter wire one cycle later. When the wire is looped back, `driveOut` follows QUAL_LEN cycles after that first wire cycle. A fault sampled at one edge clears `driveOut` one cycle later. The bench changes inputs on the falling edge and steps its reference model with exactly the values present at the next rising edge. It compares every output at the falling edge after that, so each result is judged in the cycle it becomes due. Directed sequences add fixed expected values at the points where the latency above places each change.

// File: rtl/link_pkg.sv
package link_pkg;
  typedef enum logic {
    PULSE_SET = 1'b0,
    PULSE_RST = 1'b1
  } pulseKind_t;

  typedef struct packed {
    logic takeSet;
    logic takeRst;
    logic forceOff;
  } rxStrobe_t;
endpackage

// File: rtl/link_tx.sv
module link_tx
  import link_pkg::*;
#(
  parameter int PULSE_LEN = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic cmdIn,
  output logic chanSetOut,
  output logic chanRstOut
);
  localparam int CW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;

  logic cmdPrev, busy, pendV;
  pulseKind_t kind, pendK, edgeKind;
  logic [CW-1:0] cnt;
  logic rise, fall, edgeSeen, lastCycle;

  assign rise      = cmdIn & ~cmdPrev;
  assign fall      = ~cmdIn & cmdPrev;
  assign edgeSeen  = rise | fall;
  assign edgeKind  = rise ? PULSE_SET : PULSE_RST;
  assign lastCycle = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdPrev <= 1'b0;
      busy    <= 1'b0;
      pendV   <= 1'b0;
      kind    <= PULSE_SET;
      pendK   <= PULSE_SET;
      cnt     <= '0;
    end else begin
      cmdPrev <= cmdIn;
      if (!busy || lastCycle) begin
        if (edgeSeen) begin
          busy  <= 1'b1;
          kind  <= edgeKind;
          cnt   <= CW'(PULSE_LEN - 1);
          pendV <= 1'b0;
        end else if (pendV) begin
          busy  <= 1'b1;
          kind  <= pendK;
          cnt   <= CW'(PULSE_LEN - 1);
          pendV <= 1'b0;
        end else begin
          busy <= 1'b0;
        end
      end else begin
        cnt <= cnt - 1'b1;
        if (edgeSeen) begin
          pendV <= 1'b1;
          pendK <= edgeKind;
        end
      end
    end
  end

  assign chanSetOut = busy && (kind == PULSE_SET);
  assign chanRstOut = busy && (kind == PULSE_RST);

  // R1: an idle transmitter answers a rising command with a turn-on pulse
  assert_rise_sends_set_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && rise) |=> chanSetOut);

  // R1: an idle transmitter answers a falling command with a turn-off pulse
  assert_fall_sends_rst_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && fall) |=> chanRstOut);
endmodule

// File: rtl/link_rx_ctrl.sv
module link_rx_ctrl
  import link_pkg::*;
#(
  parameter int QUAL_LEN = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxSet,
  input  logic      rxRst,
  input  logic      fault,
  output rxStrobe_t strobe
);
  localparam int QW = $clog2(QUAL_LEN + 1);

  logic [QW-1:0] cntS, cntR;
  logic soloS, soloR;

  assign soloS = rxSet & ~rxRst;
  assign soloR = rxRst & ~rxSet;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntS <= '0;
      cntR <= '0;
    end else begin
      cntS <= !soloS ? '0 : ((cntS == QW'(QUAL_LEN)) ? cntS : cntS + 1'b1);
      cntR <= !soloR ? '0 : ((cntR == QW'(QUAL_LEN)) ? cntR : cntR + 1'b1);
    end
  end

  assign strobe.takeSet  = soloS && (cntS == QW'(QUAL_LEN - 1));
  assign strobe.takeRst  = soloR && (cntR == QW'(QUAL_LEN - 1));
  assign strobe.forceOff = fault;

  generate
    if (QUAL_LEN > 1) begin : gQualChk
      // R4: acceptance needs the previous sample to be a solo cycle as well
      assert_set_qualified_R4: assert property (@(posedge clk) disable iff (!rstN)
        strobe.takeSet |-> $past(rxSet && !rxRst));
      assert_rst_qualified_R4: assert property (@(posedge clk) disable iff (!rstN)
        strobe.takeRst |-> $past(rxRst && !rxSet));
    end
  endgenerate
endmodule

// File: rtl/link_rx_dp.sv
module link_rx_dp
  import link_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  rxStrobe_t strobe,
  output logic      driveOut
);
  always_ff @(posedge clk) begin
    if (!rstN)                driveOut <= 1'b0;
    else if (strobe.forceOff) driveOut <= 1'b0;
    else if (strobe.takeSet)  driveOut <= 1'b1;
    else if (strobe.takeRst)  driveOut <= 1'b0;
  end

  // R7: a fault clears the held state by the next cycle
  assert_fault_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.forceOff |=> !driveOut);

  // R5: without an accepted pulse or a fault the held state does not move
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.takeSet && !strobe.takeRst && !strobe.forceOff) |=> $stable(driveOut));
endmodule

// File: rtl/edge_pulse_link.sv
module edge_pulse_link
  import link_pkg::*;
#(
  parameter int PULSE_LEN = 6,
  parameter int QUAL_LEN  = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic cmdIn,
  input  logic faultIn,
  input  logic rxSetIn,
  input  logic rxRstIn,
  output logic chanSetOut,
  output logic chanRstOut,
  output logic driveOut
);
  rxStrobe_t rxStrobe;

  link_tx #(.PULSE_LEN(PULSE_LEN)) i_tx (
    .clk(clk), .rstN(rstN), .cmdIn(cmdIn),
    .chanSetOut(chanSetOut), .chanRstOut(chanRstOut)
  );

  link_rx_ctrl #(.QUAL_LEN(QUAL_LEN)) i_rxCtrl (
    .clk(clk), .rstN(rstN), .rxSet(rxSetIn), .rxRst(rxRstIn),
    .fault(faultIn), .strobe(rxStrobe)
  );

  link_rx_dp i_rxDp (
    .clk(clk), .rstN(rstN), .strobe(rxStrobe), .driveOut(driveOut)
  );

  // R6: a common-mode cycle never moves the held output
  assert_common_mode_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rxSetIn && rxRstIn && !faultIn) |=> $stable(driveOut));
endmodule

// File: tb/test_edge_pulse_link.sv
module test_edge_pulse_link;
  localparam int P = 6;
  localparam int Q = 3;

  logic clk = 1'b0, rstN = 1'b0, cmd = 1'b0, fault = 1'b0;
  logic injS = 1'b0, injR = 1'b0, loopOn = 1'b1;
  logic chanSet, chanRst, drive, rxS, rxR;
  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int mPrev = 0, mBusy = 0, mCnt = 0, mKind = 0, mPendV = 0, mPendK = 0;
  int mCntS = 0, mCntR = 0, mQ = 0;

  always #5 clk = ~clk;

  assign rxS = (loopOn & chanSet) | injS;
  assign rxR = (loopOn & chanRst) | injR;

  edge_pulse_link #(.PULSE_LEN(P), .QUAL_LEN(Q)) i_edge_pulse_link (
    .clk(clk), .rstN(rstN), .cmdIn(cmd), .faultIn(fault),
    .rxSetIn(rxS), .rxRstIn(rxR),
    .chanSetOut(chanSet), .chanRstOut(chanRst), .driveOut(drive)
  );

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  function automatic logic expSet();
    return logic'(mBusy != 0 && mKind == 0);
  endfunction

  function automatic logic expRst();
    return logic'(mBusy != 0 && mKind == 1);
  endfunction

  task automatic modelStep();
    int rise, fall, ek, soloS, soloR, takeS, takeR;
    if (!rstN) begin
      mPrev = 0; mBusy = 0; mCnt = 0; mKind = 0; mPendV = 0; mPendK = 0;
      mCntS = 0; mCntR = 0; mQ = 0;
      return;
    end
    rise = (cmd && mPrev == 0);
    fall = (!cmd && mPrev == 1);
    ek = rise ? 0 : 1;
    soloS = (rxS && !rxR);
    soloR = (rxR && !rxS);
    takeS = soloS && (mCntS == Q - 1);
    takeR = soloR && (mCntR == Q - 1);
    if (mBusy == 0 || mCnt == 0) begin
      if (rise || fall) begin mBusy = 1; mKind = ek; mCnt = P - 1; mPendV = 0; end
      else if (mPendV != 0) begin mBusy = 1; mKind = mPendK; mCnt = P - 1; mPendV = 0; end
      else mBusy = 0;
    end else begin
      mCnt = mCnt - 1;
      if (rise || fall) begin mPendV = 1; mPendK = ek; end
    end
    mPrev = cmd ? 1 : 0;
    mCntS = soloS ? ((mCntS == Q) ? Q : mCntS + 1) : 0;
    mCntR = soloR ? ((mCntR == Q) ? Q : mCntR + 1) : 0;
    if (fault) mQ = 0;
    else if (takeS) mQ = 1;
    else if (takeR) mQ = 0;
  endtask

  task automatic tick(string tag, logic c, logic f = 1'b0, logic s = 1'b0,
                      logic r = 1'b0, logic n = 1'b1);
    @(negedge clk);
    chk(tag, "chanSetOut", chanSet, expSet());
    chk(tag, "chanRstOut", chanRst, expRst());
    chk(tag, "driveOut", drive, logic'(mQ));
    chk("R2", "one-wire", logic'(chanSet && chanRst), 1'b0);
    rstN = n; cmd = c; fault = f; injS = s; injR = r;
    #1;
    modelStep();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog timeout actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic c, f;
    seed = $urandom(32'd2024);
    // R9: reset state
    for (int i = 0; i < 3; i++) tick("R9", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9", "driveOut after reset", drive, 1'b0);
    chk("R9", "chanSetOut after reset", chanSet, 1'b0);
    // R1: rising command, looped back
    tick("R1", 1'b1);
    for (int i = 0; i < 10; i++) tick("R1", 1'b1);
    chk("R1", "driveOut after turn-on", drive, 1'b1);
    for (int i = 0; i < 10; i++) begin
      tick("R1", 1'b1);
      chk("R1", "steady level sends nothing", chanSet | chanRst, 1'b0);
    end
    // R3: fall then rise during the turn-off pulse
    tick("R3", 1'b0);
    tick("R3", 1'b1);
    for (int i = 0; i < 16; i++) tick("R3", 1'b1);
    chk("R3", "queued turn-on delivered", drive, 1'b1);
    loopOn = 1'b0;
    // R5: short turn-off run
    for (int i = 0; i < Q - 1; i++) tick("R5", 1'b1, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) tick("R5", 1'b1);
    chk("R5", "short run ignored", drive, 1'b1);
    // R6: common-mode cycle splits a run
    tick("R6", 1'b1, 1'b0, 1'b0, 1'b1);
    tick("R6", 1'b1, 1'b0, 1'b0, 1'b1);
    tick("R6", 1'b1, 1'b0, 1'b1, 1'b1);
    tick("R6", 1'b1, 1'b0, 1'b0, 1'b1);
    tick("R6", 1'b1, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 6; i++) tick("R6", 1'b1, 1'b0, 1'b1, 1'b1);
    tick("R6", 1'b1);
    tick("R6", 1'b1);
    chk("R6", "common mode leaves output", drive, 1'b1);
    // R7: fault clears output, turn-on ignored during fault
    tick("R7", 1'b1, 1'b1);
    tick("R7", 1'b1, 1'b1);
    chk("R7", "fault forces off", drive, 1'b0);
    for (int i = 0; i < 5; i++) tick("R7", 1'b1, 1'b1, 1'b1, 1'b0);
    tick("R7", 1'b1, 1'b1);
    chk("R7", "turn-on masked by fault", drive, 1'b0);
    // R8: stays off after fault clears until a fresh turn-on
    for (int i = 0; i < 4; i++) tick("R8", 1'b1);
    chk("R8", "still off after fault", drive, 1'b0);
    for (int i = 0; i < Q; i++) tick("R8", 1'b1, 1'b0, 1'b1, 1'b0);
    tick("R8", 1'b1);
    chk("R8", "fresh turn-on accepted", drive, 1'b1);
    // R4: exact-length turn-off run
    for (int i = 0; i < Q; i++) tick("R4", 1'b1, 1'b0, 1'b0, 1'b1);
    tick("R4", 1'b1);
    chk("R4", "turn-off run accepted", drive, 1'b0);
    loopOn = 1'b1;
    // R9: reset in the middle of a pulse
    tick("R9", 1'b0);
    tick("R9", 1'b0);
    tick("R9", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    tick("R9", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9", "pulse cleared by reset", chanRst, 1'b0);
    chk("R9", "output cleared by reset", drive, 1'b0);
    // R4: constrained random traffic checked against the model
    c = 1'b0; f = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(7) == 0) c = ~c;
      if ($urandom_range(63) == 0) f = ~f;
      tick("R4", c, f, logic'($urandom_range(15) == 0), logic'($urandom_range(15) == 0));
    end
    tick("R4", c);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule